// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast clock by a total ratio of P×N+A and emits one comparison pulse per complete division. It models the feedback path of a frequency synthesizer. An internal prescaler divides by either P or P+1. An 11-bit main counter N counts prescaler periods, and a 7-bit swallow counter A decides how many of those periods use the longer modulus. A mode bit selects the base modulus P: 64 when the bit is 1, and 128 when it is 0. The result is a fine-grained ratio built from two coarse counters.

Settings are captured from the input pins on a clock edge where the load strobe is high. They take effect only at the next division boundary, so a change never tears the division that is already running. Settings outside the legal range raise an error flag. The divider keeps running with substitute values, so it never stalls.

Top module: `pswFeedbackDivider`

## Requirements
- R1: During reset `fpPulse` and `cfgErr` are low. The reset setting is N=3, A=0, mode bit 1, so out of reset the pulses are 192 fast cycles apart.
- R2: With mode bit `modSel`=1, consecutive `fpPulse` rising edges are 64×N+A fast cycles apart.
- R3: With `modSel`=0, consecutive `fpPulse` rising edges are 128×N+A fast cycles apart.
- R4: With A=0 the spacing is exactly P×N, with no stretched prescaler period.
- R5: `fpPulse` is high for exactly one fast cycle per division. Two pulses are never closer than 192 cycles.
- R6: A setting loaded in the middle of a division does not change that division. The division in progress ends at the old spacing, and the new spacing applies from the following division.
- R7: A loaded N below 3 raises `cfgErr` and counts as N=3.
- R8: A loaded A not less than the loaded N raises `cfgErr`. When A is not less than max(N,3), the swallow count used is 0.
- R9: `cfgErr` reflects the most recently loaded setting. It changes in the cycle after the loading edge, and a legal load clears it.
- R10: While `loadStb` is low, changes on `divMain`, `divSwallow` and `modSel` have no effect on the spacing or on `cfgErr`.
- R11: The largest swallow count, A=127 (with N=128, `modSel`=1), gives a spacing of 8319 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock being divided |
| rstN | input | 1 | Asynchronous reset, active low |
| loadStb | input | 1 | Captures the three setting inputs on this edge |
| divMain | input | 11 | Main count N |
| divSwallow | input | 7 | Swallow count A |
| modSel | input | 1 | 1: P=64, 0: P=128 |
| fpPulse | output | 1 | One-cycle pulse per completed division |
| cfgErr | output | 1 | Loaded setting is outside the legal range |

## Verification
The hardest case to reach from the ports is a load that lands in the middle of a division. It must leave that division alone while the modulus, main count and swallow count are all changing at once. Each scenario first synchronises to a pulse and then loads a few cycles later, so the load is always inside a running division. It then measures two intervals: the one that ends the current division (old spacing) and the next one (new spacing). Illegal settings are loaded the same way, so each one exercises the substitute values at a real boundary.

// File: rtl/pswDivPkg.sv
`timescale 1ns/1ps
package pswDivPkg;

  // Strobes from control to datapath, valid for one fast cycle
  typedef struct packed {
    logic cntStep;    // prescaler period ends this cycle
    logic cycleWrap;  // whole division ends this cycle
    logic nextHigh;   // next prescaler period uses modulus P+1
  } divStrb_t;

endpackage

// File: rtl/pswCfgShadow.sv
`timescale 1ns/1ps
module pswCfgShadow #(
  parameter int MAIN_W   = 11,
  parameter int SWAL_W   = 7,
  parameter int MAIN_MIN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadStb,
  input  logic [MAIN_W-1:0] divMain,
  input  logic [SWAL_W-1:0] divSwallow,
  input  logic              modSel,
  output logic [MAIN_W-1:0] effMain,
  output logic [SWAL_W-1:0] effSwallow,
  output logic              effSw,
  output logic              effSwalNz,
  output logic              cfgErr
);

  localparam int PAD = MAIN_W - SWAL_W;

  logic [MAIN_W-1:0] shMain;
  logic [SWAL_W-1:0] shSwal;
  logic              shSw;
  logic [MAIN_W-1:0] swalWide;
  logic              mainLow;
  logic              swalBad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shMain <= MAIN_W'(MAIN_MIN);
      shSwal <= '0;
      shSw   <= 1'b1;
    end else if (loadStb) begin
      shMain <= divMain;
      shSwal <= divSwallow;
      shSw   <= modSel;
    end
  end

  always_comb begin
    swalWide   = {{PAD{1'b0}}, shSwal};
    mainLow    = shMain < MAIN_W'(MAIN_MIN);
    effMain    = mainLow ? MAIN_W'(MAIN_MIN) : shMain;
    swalBad    = swalWide >= effMain;
    effSwallow = swalBad ? '0 : shSwal;
    effSwalNz  = |effSwallow;
    effSw      = shSw;
    cfgErr     = mainLow | (swalWide >= shMain);
  end

endmodule

// File: rtl/pswControl.sv
`timescale 1ns/1ps
module pswControl
  import pswDivPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     psZero,
  input  logic     mainLast,
  input  logic     swalMany,
  input  logic     effSwalNz,
  output divStrb_t strb,
  output logic     fpPulse
);

  always_comb begin
    strb.cntStep   = psZero;
    strb.cycleWrap = psZero & mainLast;
    // At a wrap the next period follows the fresh swallow count,
    // otherwise it stays long while more than one swallow remains
    strb.nextHigh  = strb.cycleWrap ? effSwalNz : swalMany;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fpPulse <= 1'b0;
    else       fpPulse <= strb.cycleWrap;
  end

endmodule

// File: rtl/pswDatapath.sv
`timescale 1ns/1ps
module pswDatapath
  import pswDivPkg::*;
#(
  parameter int MAIN_W   = 11,
  parameter int SWAL_W   = 7,
  parameter int MAIN_MIN = 3,
  parameter int PRE_LO   = 64,
  parameter int PRE_HI   = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  divStrb_t          strb,
  input  logic [MAIN_W-1:0] effMain,
  input  logic [SWAL_W-1:0] effSwallow,
  input  logic              effSw,
  output logic              psZero,
  output logic              mainLast,
  output logic              swalMany
);

  localparam int PS_W = $clog2(PRE_HI + 1);
  localparam logic [PS_W-1:0] LO_LOAD = PS_W'(PRE_LO - 1);
  localparam logic [PS_W-1:0] HI_LOAD = PS_W'(PRE_HI - 1);

  logic [PS_W-1:0]   psCnt;
  logic [MAIN_W-1:0] mainCnt;
  logic [SWAL_W-1:0] swalCnt;
  logic              actSw;
  logic              useSw;
  logic [PS_W-1:0]   psReload;

  always_comb begin
    useSw    = strb.cycleWrap ? effSw : actSw;
    psReload = (useSw ? LO_LOAD : HI_LOAD) + PS_W'(strb.nextHigh);
    psZero   = psCnt == '0;
    mainLast = mainCnt == MAIN_W'(1);
    swalMany = swalCnt > SWAL_W'(1);
  end

  // Behavioural dual-modulus prescaler: one period is psReload+1 cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             psCnt <= LO_LOAD;
    else if (strb.cntStep) psCnt <= psReload;
    else                   psCnt <= psCnt - PS_W'(1);
  end

  // Main and swallow counters advance once per prescaler period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainCnt <= MAIN_W'(MAIN_MIN);
      swalCnt <= '0;
      actSw   <= 1'b1;
    end else if (strb.cycleWrap) begin
      mainCnt <= effMain;
      swalCnt <= effSwallow;
      actSw   <= effSw;
    end else if (strb.cntStep) begin
      mainCnt <= mainCnt - MAIN_W'(1);
      if (swalCnt != '0) swalCnt <= swalCnt - SWAL_W'(1);
    end
  end

endmodule

// File: rtl/pswFeedbackDivider.sv
`timescale 1ns/1ps
module pswFeedbackDivider
  import pswDivPkg::*;
#(
  parameter int MAIN_W   = 11,
  parameter int SWAL_W   = 7,
  parameter int MAIN_MIN = 3,
  parameter int PRE_LO   = 64,
  parameter int PRE_HI   = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadStb,
  input  logic [MAIN_W-1:0] divMain,
  input  logic [SWAL_W-1:0] divSwallow,
  input  logic              modSel,
  output logic              fpPulse,
  output logic              cfgErr
);

  divStrb_t          strb;
  logic [MAIN_W-1:0] effMain;
  logic [SWAL_W-1:0] effSwallow;
  logic              effSw;
  logic              effSwalNz;
  logic              psZero;
  logic              mainLast;
  logic              swalMany;

  pswCfgShadow #(.MAIN_W(MAIN_W), .SWAL_W(SWAL_W), .MAIN_MIN(MAIN_MIN)) u_cfg (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .divMain(divMain),
    .divSwallow(divSwallow), .modSel(modSel), .effMain(effMain),
    .effSwallow(effSwallow), .effSw(effSw), .effSwalNz(effSwalNz),
    .cfgErr(cfgErr)
  );

  pswControl u_ctl (
    .clk(clk), .rstN(rstN), .psZero(psZero), .mainLast(mainLast),
    .swalMany(swalMany), .effSwalNz(effSwalNz), .strb(strb), .fpPulse(fpPulse)
  );

  pswDatapath #(.MAIN_W(MAIN_W), .SWAL_W(SWAL_W), .MAIN_MIN(MAIN_MIN),
                .PRE_LO(PRE_LO), .PRE_HI(PRE_HI)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .effMain(effMain),
    .effSwallow(effSwallow), .effSw(effSw), .psZero(psZero),
    .mainLast(mainLast), .swalMany(swalMany)
  );

endmodule

// File: rtl/pswDivChecker.sv
`timescale 1ns/1ps
module pswDivChecker #(
  parameter int MAIN_W   = 11,
  parameter int SWAL_W   = 7,
  parameter int MAIN_MIN = 3,
  parameter int PRE_LO   = 64,
  parameter int PRE_HI   = 128
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadStb,
  input logic [MAIN_W-1:0] divMain,
  input logic [SWAL_W-1:0] divSwallow,
  input logic              fpPulse,
  input logic              cfgErr
);

  localparam int MIN_GAP = MAIN_MIN * PRE_LO;
  localparam int GAP_W   = 24;
  localparam int PAD     = MAIN_W - SWAL_W;

  logic [GAP_W-1:0]  gapCnt;
  logic              seenFp;
  logic [MAIN_W-1:0] swalWide;

  assign swalWide = {{PAD{1'b0}}, divSwallow};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '0;
      seenFp <= 1'b0;
    end else if (fpPulse) begin
      gapCnt <= '0;
      seenFp <= 1'b1;
    end else if (gapCnt != {GAP_W{1'b1}}) begin
      gapCnt <= gapCnt + GAP_W'(1);
    end
  end

  p_single_fp_r5: assert property (@(posedge clk) disable iff (!rstN)
    fpPulse |=> !fpPulse);

  p_min_gap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (fpPulse && seenFp) |-> (gapCnt >= GAP_W'(MIN_GAP - 1)));

  p_err_low_main_r7: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && (divMain < MAIN_W'(MAIN_MIN))) |=> cfgErr);

  p_err_swal_r8: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && (swalWide >= divMain)) |=> cfgErr);

  p_err_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && (divMain >= MAIN_W'(MAIN_MIN)) && (swalWide < divMain)) |=> !cfgErr);

  p_err_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !loadStb |=> $stable(cfgErr));

endmodule

bind pswFeedbackDivider pswDivChecker #(
  .MAIN_W(MAIN_W), .SWAL_W(SWAL_W), .MAIN_MIN(MAIN_MIN),
  .PRE_LO(PRE_LO), .PRE_HI(PRE_HI)
) u_chk (
  .clk(clk), .rstN(rstN), .loadStb(loadStb), .divMain(divMain),
  .divSwallow(divSwallow), .fpPulse(fpPulse), .cfgErr(cfgErr)
);

// File: tb/sim_pswFeedbackDivider.sv
`timescale 1ns/1ps
module sim_pswFeedbackDivider;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadStb = 1'b0;
  logic [10:0] divMain = 11'd3;
  logic [6:0]  divSwallow = 7'd0;
  logic        modSel = 1'b1;
  logic        fpPulse;
  logic        cfgErr;

  int     nChecks = 0;
  int     nFails = 0;
  longint cyc = 0;
  longint curExp = 192;
  bit     done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pswFeedbackDivider u0 (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .divMain(divMain),
    .divSwallow(divSwallow), .modSel(modSel), .fpPulse(fpPulse), .cfgErr(cfgErr)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitFp(output longint t);
    do @(negedge clk); while (!fpPulse);
    t = cyc;
  endtask

  task automatic loadCfg(input int n, input int a, input bit sw);
    divMain = 11'(n);
    divSwallow = 7'(a);
    modSel = sw;
    loadStb = 1'b1;
    @(negedge clk);
    loadStb = 1'b0;
  endtask

  // Load inside a running division, then check the old and new spacing
  task automatic applyRatio(input int n, input int a, input bit sw,
                            input longint expP, input bit expErr, input string tag);
    longint t0, t1, t2;
    waitFp(t0);
    repeat (3) @(negedge clk);
    loadCfg(n, a, sw);
    chk(cfgErr == expErr, {tag, " error flag"}, cfgErr, expErr);
    waitFp(t1);
    chk(t1 - t0 == curExp, "R6 running division keeps old ratio", t1 - t0, curExp);
    waitFp(t2);
    chk(t2 - t1 == expP, {tag, " spacing"}, t2 - t1, expP);
    curExp = expP;
  endtask

  task automatic testReset();
    longint t0, t1;
    repeat (4) @(negedge clk);
    chk(fpPulse == 1'b0, "R1 fpPulse in reset", fpPulse, 0);
    chk(cfgErr == 1'b0, "R1 cfgErr in reset", cfgErr, 0);
    rstN = 1'b1;
    waitFp(t0);
    waitFp(t1);
    chk(t1 - t0 == 192, "R1 default spacing", t1 - t0, 192);
  endtask

  task automatic testWidth();
    longint t0;
    waitFp(t0);
    @(negedge clk);
    chk(fpPulse == 1'b0, "R5 pulse one cycle wide", fpPulse, 0);
  endtask

  task automatic testLowMode();   applyRatio(5, 3, 1'b1, 323, 1'b0, "R2"); endtask
  task automatic testHighMode();  applyRatio(4, 1, 1'b0, 513, 1'b0, "R3"); endtask
  task automatic testNoSwallow(); applyRatio(3, 0, 1'b0, 384, 1'b0, "R4"); endtask

  task automatic testMainTooSmall();
    applyRatio(1, 0, 1'b1, 192, 1'b1, "R7");
    applyRatio(2, 2, 1'b1, 194, 1'b1, "R7");
  endtask

  task automatic testSwallowTooBig();
    applyRatio(4, 4, 1'b1, 256, 1'b1, "R8");
    applyRatio(4, 9, 1'b1, 256, 1'b1, "R8");
  endtask

  task automatic testErrClear();
    applyRatio(6, 5, 1'b1, 389, 1'b0, "R9");
  endtask

  task automatic testIgnore();
    longint t0, t1, t2;
    waitFp(t0);
    repeat (2) @(negedge clk);
    divMain = 11'd2;
    divSwallow = 7'd100;
    modSel = 1'b0;
    @(negedge clk);
    chk(cfgErr == 1'b0, "R10 cfgErr ignores pins", cfgErr, 0);
    waitFp(t1);
    chk(t1 - t0 == curExp, "R10 spacing ignores pins", t1 - t0, curExp);
    waitFp(t2);
    chk(t2 - t1 == curExp, "R10 spacing ignores pins", t2 - t1, curExp);
  endtask

  task automatic testMaxSwallow();
    applyRatio(128, 127, 1'b1, 8319, 1'b0, "R11");
  endtask

  initial begin
    testReset();
    testWidth();
    testLowMode();
    testHighMode();
    testNoSwallow();
    testMainTooSmall();
    testSwallowTooBig();
    testErrClear();
    testIgnore();
    testMaxSwallow();
    testWidth();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule